// File: doc/BRIEF.md
# Dual-Rail Encoder with Completion Detection

This block turns a plain binary word into a two-wire-per-bit form for a self-timed datapath. Every bit gets a true wire and a false wire. Driving the true wire means logic 1, and driving the false wire means logic 0. When both wires are low, the bit is empty. The encoder never lets two data words follow each other directly: an all-empty spacer word must sit between them. The rails rise for a new word and fall together for the spacer.

A completion detector watches a dual-rail word and reports two things: that every bit carries a value (all-data), or that every bit is empty (all-null). While the word is only partly filled, or partly drained, it keeps its last report. It also flags any pair that has both wires high, and it gives back the word taken from the true rails.

Normally the detector watches the encoder's own output. The encoder waits for that all-null report before it will accept the next word, so data and spacer always alternate. An injection path lets the detector watch an arbitrary dual-rail word instead, so illegal and mixed codes can be presented to it. Everything is modelled with clocked registers so it can be tested in a synchronous flow.

Top module: `dr_codec`

## Requirements
- R1: After a clock edge with `rst_n` low, all rails are 0, `all_null` is 1, `all_data` is 0, `code_err` is 0, `dec_word` is 0, and the encoder will accept a word.
- R2: A load is accepted when `go_data` is 1 and the encoder is armed. After that edge, for each bit i, `rail_t[i]` equals `din[i]` and `rail_f[i]` equals the inverse of `din[i]`. So a pair (t,f) reads 10 for logic 1 and 01 for logic 0.
- R3: An edge with `go_data` at 0 drives every rail to 0 (spacer, pair 00).
- R4: A refused load leaves the rails unchanged. The encoder is disarmed by an accepted load. It is re-armed only by an edge at which `all_null` is already 1 and the rails are all 0. The earliest accepted reload is therefore the third edge after the edge that produced the spacer.
- R5: One edge after the monitored word has every pair at 01 or 10, `all_data` is 1 and `all_null` is 0.
- R6: One edge after the monitored word has every pair at 00, `all_null` is 1 and `all_data` is 0.
- R7: A monitored word that is neither fully valid nor fully empty leaves `all_data` and `all_null` unchanged. This includes any word with a pair at 11.
- R8: `code_err` is 1 one edge after a monitored word that contains at least one pair at 11, and 0 one edge after any other word.
- R9: `dec_word` takes the true rails of each fully valid monitored word and otherwise holds. While `all_data` is 1 on the encoder's own output, it equals the word that was loaded.
- R10: The encoder's rails are monotonic. From a non-empty word they either hold or all drop to 0. From the empty word they either hold or become a fully valid word. No pair is ever 11.
- R11: With `inj_en` at 1, the detector watches `inj_t`/`inj_f` instead of the encoder rails. The encoder and its arming are unaffected by this selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_data | input | 1 | 1: present `din` as data; 0: present the spacer |
| din | input | WIDTH | Single-rail word to encode |
| inj_en | input | 1 | Detector watches the injection rails instead of the encoder |
| inj_t | input | WIDTH | Injected true rails |
| inj_f | input | WIDTH | Injected false rails |
| rail_t | output | WIDTH | Encoder true rails |
| rail_f | output | WIDTH | Encoder false rails |
| all_data | output | 1 | Monitored word reported fully valid |
| all_null | output | 1 | Monitored word reported fully empty |
| code_err | output | 1 | A pair at 11 was seen on the last edge |
| dec_word | output | WIDTH | Value from the true rails of the last complete word |

## Verification
The encoder alone only ever produces clean all-valid or all-empty words, so the hold behaviour for partial words and the illegal-pair flag cannot be reached through it. The stimulus uses the injection port to present half-filled words, words with a single 11 pair, and clean words. It does this while the encoder sits in data or spacer phase, which also shows that the encoder keeps its rails. The re-arm timing is a second hard spot: the detector's stale all-null report, sampled on the edge right after a load, must not re-arm the encoder. Directed sequences request a reload on each edge right after a spacer to find the exact cycle at which a load is first accepted.

// File: rtl/dr_codec_pkg.sv
// Package: shared pair encoding for the dual-rail codec.
// A pair is written {true_rail, false_rail}.
package dr_codec_pkg;

    typedef enum logic [1:0] {
        PR_NULL = 2'b00,
        PR_ZERO = 2'b01,
        PR_ONE  = 2'b10,
        PR_BAD  = 2'b11
    } pair_e;

    // Classify one rail pair.
    function automatic pair_e pair_of(input logic t, input logic f);
        return pair_e'({t, f});
    endfunction

endpackage

// File: rtl/dr_pair_class.sv
// Module: dr_pair_class
// Classifies one rail pair as valid (one wire high), empty, or illegal.
// Assumes: purely combinational, no state.
module dr_pair_class
    import dr_codec_pkg::*;
(
    input  logic t_in,
    input  logic f_in,
    output logic is_valid,
    output logic is_null,
    output logic is_bad
);
    pair_e kind;

    // Decode the pair into its three exclusive classes.
    always_comb begin
        kind     = pair_of(t_in, f_in);
        is_valid = (kind == PR_ZERO) || (kind == PR_ONE);
        is_null  = (kind == PR_NULL);
        is_bad   = (kind == PR_BAD);
    end
endmodule

// File: rtl/dr_detector.sv
// Module: dr_detector
// Completion detector: registers all-valid / all-empty reports with hold
// on mixed words, flags illegal pairs, and captures the true rails.
// Assumes: mon_* are stable around the clock edge (synchronous model).
module dr_detector #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] mon_t,
    input  logic [WIDTH-1:0] mon_f,
    output logic             all_data,
    output logic             all_null,
    output logic             code_err,
    output logic [WIDTH-1:0] dec_word
);
    logic [WIDTH-1:0] bit_valid;
    logic [WIDTH-1:0] bit_null;
    logic [WIDTH-1:0] bit_bad;
    logic             word_valid;
    logic             word_null;
    logic             word_bad;

    // One classifier per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        dr_pair_class u_cls (
            .t_in     (mon_t[i]),
            .f_in     (mon_f[i]),
            .is_valid (bit_valid[i]),
            .is_null  (bit_null[i]),
            .is_bad   (bit_bad[i])
        );
    end

    // Word-level reduction of the per-bit results.
    always_comb begin
        word_valid = &bit_valid;
        word_null  = &bit_null;
        word_bad   = |bit_bad;
    end

    // Report registers: change only on a uniform word, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_data <= 1'b0;
            all_null <= 1'b1;
            code_err <= 1'b0;
            dec_word <= '0;
        end else begin
            code_err <= word_bad;
            if (word_valid) begin
                all_data <= 1'b1;
                all_null <= 1'b0;
                dec_word <= mon_t;
            end else if (word_null) begin
                all_data <= 1'b0;
                all_null <= 1'b1;
            end
        end
    end

    // History qualifier so $past never looks before reset.
    logic hist_ok;
    always_ff @(posedge clk) hist_ok <= rst_n;

    a_r5_data_report: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        $past(word_valid) |-> (all_data && !all_null));
    a_r6_null_report: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        $past(word_null) |-> (all_null && !all_data));
    a_r7_hold_mixed: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        (!$past(word_valid) && !$past(word_null)) |-> ($stable(all_data) && $stable(all_null)));
    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        code_err == $past(word_bad));
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({all_data, all_null}) == 1);
endmodule

// File: rtl/dr_encoder.sv
// Module: dr_encoder
// Encodes a single-rail word onto true/false rails, inserts spacers, and
// refuses a new word until an all-empty report has been seen on an empty bus.
// Assumes: det_null is the registered report of the detector.
module dr_encoder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_data,
    input  logic [WIDTH-1:0] din,
    input  logic             det_null,
    output logic [WIDTH-1:0] rail_t,
    output logic [WIDTH-1:0] rail_f
);
    logic armed;
    logic out_null;
    logic load;

    // Accept decision and empty-bus sense.
    always_comb begin
        out_null = ~|(rail_t | rail_f);
        load     = go_data && armed;
    end

    // Rail and arming registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_t <= '0;
            rail_f <= '0;
            armed  <= 1'b1;
        end else if (load) begin
            rail_t <= din;
            rail_f <= ~din;
            armed  <= 1'b0;
        end else begin
            if (!go_data) begin
                rail_t <= '0;
                rail_f <= '0;
            end
            armed <= armed | (det_null & out_null);
        end
    end

    logic hist_ok;
    always_ff @(posedge clk) hist_ok <= rst_n;

    a_r10_no_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t & rail_f) == '0);
    a_r10_fall_all: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        !$past(out_null) |-> ($stable(rail_t) && $stable(rail_f)) || out_null);
    a_r10_rise_all: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        $past(out_null) |-> out_null || ((rail_t ^ rail_f) == '1));
    a_r3_spacer: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        !$past(go_data) |-> out_null);
    a_r4_armed_load: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        ($past(out_null) && !out_null) |-> $past(armed));
endmodule

// File: rtl/dr_codec.sv
// Module: dr_codec (top)
// Dual-rail encoder plus completion detector; the detector watches either
// the encoder rails or an injected word.
// Assumes: single clock, synchronous active-low reset.
module dr_codec #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_data,
    input  logic [WIDTH-1:0] din,
    input  logic             inj_en,
    input  logic [WIDTH-1:0] inj_t,
    input  logic [WIDTH-1:0] inj_f,
    output logic [WIDTH-1:0] rail_t,
    output logic [WIDTH-1:0] rail_f,
    output logic             all_data,
    output logic             all_null,
    output logic             code_err,
    output logic [WIDTH-1:0] dec_word
);
    logic [WIDTH-1:0] mon_t;
    logic [WIDTH-1:0] mon_f;

    // Detector source select.
    always_comb begin
        mon_t = inj_en ? inj_t : rail_t;
        mon_f = inj_en ? inj_f : rail_f;
    end

    dr_encoder #(.WIDTH(WIDTH)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_data  (go_data),
        .din      (din),
        .det_null (all_null),
        .rail_t   (rail_t),
        .rail_f   (rail_f)
    );

    dr_detector #(.WIDTH(WIDTH)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_t    (mon_t),
        .mon_f    (mon_f),
        .all_data (all_data),
        .all_null (all_null),
        .code_err (code_err),
        .dec_word (dec_word)
    );

    logic hist_ok;
    always_ff @(posedge clk) hist_ok <= rst_n;

    a_r9_dec_matches: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
        (all_data && !$past(inj_en) && $past(rail_t != 0 || rail_f != 0)) |-> dec_word == $past(rail_t));
endmodule

// File: tb/sim_dr_codec.sv
module sim_dr_codec;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         go_data;
    logic [W-1:0] din;
    logic         inj_en;
    logic [W-1:0] inj_t;
    logic [W-1:0] inj_f;
    logic [W-1:0] rail_t;
    logic [W-1:0] rail_f;
    logic         all_data;
    logic         all_null;
    logic         code_err;
    logic [W-1:0] dec_word;

    always #4 clk = ~clk;   // 125 MHz

    dr_codec #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .go_data(go_data), .din(din),
        .inj_en(inj_en), .inj_t(inj_t), .inj_f(inj_f),
        .rail_t(rail_t), .rail_f(rail_f), .all_data(all_data),
        .all_null(all_null), .code_err(code_err), .dec_word(dec_word)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference state, written from the requirements.
    logic [W-1:0] m_t, m_f, m_dec;
    logic         m_armed, m_ad, m_an, m_err;

    function automatic bit word_all_valid(input logic [W-1:0] t, input logic [W-1:0] f);
        return ((t ^ f) == '1);
    endfunction

    function automatic bit word_all_null(input logic [W-1:0] t, input logic [W-1:0] f);
        return ((t | f) == '0);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance the reference by one clock edge using the applied inputs.
    task automatic model_edge();
        logic [W-1:0] mt, mf;
        logic         ld, onull;
        if (!rst_n) begin   // R1
            m_t = '0; m_f = '0; m_armed = 1'b1;
            m_ad = 1'b0; m_an = 1'b1; m_err = 1'b0; m_dec = '0;
            return;
        end
        mt    = inj_en ? inj_t : m_t;   // R11
        mf    = inj_en ? inj_f : m_f;
        onull = word_all_null(m_t, m_f);
        ld    = go_data && m_armed;
        // encoder: R2, R3, R4
        if (ld) begin
            m_t = din; m_f = ~din; m_armed = 1'b0;
        end else begin
            m_armed = m_armed | (m_an & onull);
            if (!go_data) begin m_t = '0; m_f = '0; end
        end
        // detector: R5, R6, R7, R8, R9
        m_err = |(mt & mf);
        if (word_all_valid(mt, mf)) begin
            m_ad = 1'b1; m_an = 1'b0; m_dec = mt;
        end else if (word_all_null(mt, mf)) begin
            m_ad = 1'b0; m_an = 1'b1;
        end
    endtask

    task automatic compare_all();
        chk(rail_t == m_t, "R2/R3/R4 rail_t", 32'(rail_t), 32'(m_t));
        chk(rail_f == m_f, "R2/R3/R4 rail_f", 32'(rail_f), 32'(m_f));
        chk(all_data == m_ad, "R5/R7 all_data", 32'(all_data), 32'(m_ad));
        chk(all_null == m_an, "R6/R7 all_null", 32'(all_null), 32'(m_an));
        chk(code_err == m_err, "R8 code_err", 32'(code_err), 32'(m_err));
        chk(dec_word == m_dec, "R9 dec_word", 32'(dec_word), 32'(m_dec));
        chk((rail_t & rail_f) == '0, "R10 no 11 pair", 32'(rail_t & rail_f), 32'h0);
    endtask

    // One cycle: apply inputs at negedge, take the edge, update reference.
    task automatic cycle(input bit g, input logic [W-1:0] d, input bit ie,
                         input logic [W-1:0] it, input logic [W-1:0] iff_);
        go_data = g; din = d; inj_en = ie; inj_t = it; inj_f = iff_;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    logic [W-1:0] prev_t, prev_f;

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; go_data = 0; din = '0; inj_en = 0; inj_t = '0; inj_f = '0;
        @(negedge clk);
        cycle(0, '0, 0, '0, '0);
        cycle(0, '0, 0, '0, '0);
        // R1: reset state
        chk(rail_t == 0 && rail_f == 0 && all_null && !all_data && !code_err && dec_word == 0,
            "R1 reset state", {rail_t, rail_f, 8'(all_data), 8'(all_null)}, 32'h00000001);
        rst_n = 1'b1;

        // R2: first load accepted straight after reset
        cycle(1, 8'hA5, 0, '0, '0);
        chk(rail_t == 8'hA5 && rail_f == 8'h5A, "R2 encode A5", {16'h0, rail_t, rail_f}, 32'h0000A55A);
        // R5, R9: completion one edge later
        cycle(1, 8'h3C, 0, '0, '0);
        chk(all_data && dec_word == 8'hA5, "R5 R9 complete A5", {23'h0, all_data, dec_word}, 32'h000001A5);
        // R4: reload refused while data held
        chk(rail_t == 8'hA5, "R4 reload refused", 32'(rail_t), 32'hA5);
        // R3: spacer
        cycle(0, 8'h3C, 0, '0, '0);
        chk(rail_t == 0 && rail_f == 0, "R3 spacer", {rail_t, rail_f}, 32'h0);
        // R4: reload requested on the next two edges is refused, third accepted
        cycle(1, 8'h3C, 0, '0, '0);
        chk(all_null && rail_t == 0, "R6 R4 null seen, still refused", {all_null, rail_t}, 32'h100);
        cycle(1, 8'h3C, 0, '0, '0);
        chk(rail_t == 0 && rail_f == 0, "R4 second edge refused", {rail_t, rail_f}, 32'h0);
        cycle(1, 8'h3C, 0, '0, '0);
        chk(rail_t == 8'h3C && rail_f == 8'hC3, "R4 third edge accepted", {rail_t, rail_f}, 32'h3CC3);

        // R7, R11: mixed injected word holds flags; encoder keeps its rails
        cycle(1, 8'h3C, 0, '0, '0);           // all_data=1 from 3C
        prev_t = rail_t; prev_f = rail_f;
        cycle(1, 8'hFF, 1, 8'h0F, 8'h00);     // lower bits valid, upper empty
        chk(all_data && !all_null, "R7 mixed holds", {all_data, all_null}, 32'h2);
        chk(rail_t == prev_t && rail_f == prev_f, "R11 encoder unaffected", 32'(rail_t), 32'(prev_t));
        // R8: illegal pair
        cycle(1, 8'hFF, 1, 8'h81, 8'h7E | 8'h01);
        chk(code_err && all_data, "R8 illegal flagged, flags held", {code_err, all_data}, 32'h3);
        // R6, R11: injected null clears all_data even while encoder shows data
        cycle(1, 8'hFF, 1, 8'h00, 8'h00);
        chk(all_null && !code_err, "R6 injected null", {all_null, code_err}, 32'h2);
        // R11: the encoder is not re-armed by that null (its rails are not empty)
        cycle(1, 8'h11, 0, '0, '0);
        chk(rail_t == 8'h3C, "R11 R4 no re-arm via injection", 32'(rail_t), 32'h3C);

        // Constrained random
        begin
            bit g = 1'b1;
            for (int n = 0; n < 4000; n++) begin
                logic [W-1:0] d, vt, vf;
                bit ie;
                int mode;
                if ($urandom % 5 == 0) g = ~g;
                d    = W'($urandom);
                ie   = ($urandom % 8 == 0);
                mode = $urandom % 4;
                case (mode)
                    0: begin vt = W'($urandom); vf = ~vt; end
                    1: begin vt = '0; vf = '0; end
                    2: begin vt = W'($urandom); vf = W'($urandom) & ~vt; end
                    default: begin vt = W'($urandom); vf = W'($urandom); end
                endcase
                if (n == 2000) begin
                    rst_n = 1'b0;
                    cycle(g, d, ie, vt, vf);
                    chk(all_null && rail_t == 0 && dec_word == 0, "R1 mid-run reset",
                        {all_null, rail_t, dec_word}, 32'h10000);
                    rst_n = 1'b1;
                end else begin
                    cycle(g, d, ie, vt, vf);
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule